// File: doc/BRIEF.md
# Framing Packet Steerer

This block takes a 128-bit valid/ready word stream of packets that has no end-of-packet marker. It steers each whole packet into one of several per-packet buffers. The first word of every packet holds a 64-bit header in its low half and a 64-bit timestamp in its high half. The header carries the total packet length in bytes. From that length the block works out how many 128-bit words the packet occupies. It counts the words as they pass and raises the last flag on the final one. It is therefore the only place where packet boundaries are created for the buffers behind it.

A new packet starts only in a buffer that reports itself empty. The block searches the buffers in circular order, beginning one place after the buffer it used last. Once a packet has started, every word goes to that same buffer, whatever the empty flags do afterwards. Back-pressure comes from the ready signal of the chosen buffer. While no buffer is free at the start of a packet, the input is held off.

Top module: `pkt_steer_wr`

## Requirements
- R1: After reset, wr_index is 0 and no buf_valid bit is set. With every buffer empty, the first packet goes to buffer 0.
- R2: The packet length in bytes is the header field at bits [23:8] of the first word. The packet spans ceil(length/16) words, and buf_last is set on the final word only. No other header bit changes the framing.
- R3: A length of 0 to 16 gives a one-word packet, whose last flag comes with the header word. Any length above 4096 is clamped to 256 words.
- R4: Payload words are never parsed. A length-like value in a payload word neither ends the packet nor starts a new one.
- R5: A packet starts only in a buffer whose buf_empty bit is set in its start cycle. All its words then go to that buffer, even if that bit clears before the packet ends.
- R6: The search for a start buffer runs in circular order. It begins at the index one past the buffer of the previous packet and skips buffers whose empty bit is clear.
- R7: Between packets, while no buf_empty bit is set, in_ready is 0 and no buf_valid bit is set.
- R8: in_ready equals the buf_ready bit of the buffer being written. No word is lost or duplicated when ready is withdrawn.
- R9: Only the selected buffer sees valid, last and data. For every other buffer the valid, last and data outputs are 0.
- R10: wr_index shows the buffer of the current packet. It updates in the cycle after the header word is accepted and holds until the next packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W (128) | Input word; the first word of a packet is timestamp[127:64] and header[63:0] |
| buf_valid | output | BUFF_COUNT | Per-buffer write valid |
| buf_data | output | BUFF_COUNT*DATA_W | Per-buffer write data; slice i belongs to buffer i |
| buf_last | output | BUFF_COUNT | Per-buffer final-word flag |
| buf_ready | input | BUFF_COUNT | Per-buffer ready |
| buf_empty | input | BUFF_COUNT | Per-buffer empty status |
| wr_index | output | IDX_W (2) | Buffer of the current packet |

## Verification
Buffer allocation and end-of-packet framing fall in the same cycle when a packet is only one word long. The header word then both claims a buffer and carries the last flag. The bench provokes this with back-to-back packets of length 16 and length 0. The scoreboard then expects the flag on the header word, and it expects the next packet to take the following buffer with no lost cycle of framing. A second collision is also provoked: an empty flag clears while a long packet is being written, and at the same time ready is withdrawn on a pattern. Here the scoreboard judges that the words keep their order and stay in the first buffer.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BODY = 1'b1
  } wr_state_e;
endpackage

// File: rtl/pws_len_decode.sv
// Turns a byte length into a clamped 128-bit word count.
module pws_len_decode #(
  parameter int LEN_W          = 16,
  parameter int BYTES_PER_WORD = 16,
  parameter int MAX_WORDS      = 256,
  parameter int CNT_W          = 9
) (
  input  logic [LEN_W-1:0] len_bytes,
  output logic [CNT_W-1:0] words
);
  localparam int SHIFT = $clog2(BYTES_PER_WORD);
  localparam int RAW_W = LEN_W - SHIFT + 1;

  logic [LEN_W:0] rounded;
  logic [RAW_W-1:0] raw;

  always_comb begin
    rounded = {1'b0, len_bytes} + (LEN_W+1)'(BYTES_PER_WORD - 1);
    raw     = rounded[LEN_W:SHIFT];
    if (raw == '0) begin
      words = CNT_W'(1);
    end else if (raw > RAW_W'(MAX_WORDS)) begin
      words = CNT_W'(MAX_WORDS);
    end else begin
      words = CNT_W'(raw);
    end
  end
endmodule

// File: rtl/pws_rr_pick.sv
// Circular search for an empty buffer, starting at base.
module pws_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     empty,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  logic [N-1:0]     hit;
  logic [IDX_W-1:0] cand [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_off
      assign cand[k] = IDX_W'((32'(base) + k) % N);
      assign hit[k]  = empty[cand[k]];
    end
  endgenerate

  always_comb begin
    found = |hit;
    pick  = base;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) pick = cand[k];
    end
  end
endmodule

// File: rtl/pws_frame_ctrl.sv
// Packet state, word countdown, locked index and search base.
module pws_frame_ctrl
  import pws_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sel_ready,
  input  logic             found,
  input  logic [IDX_W-1:0] pick,
  input  logic [CNT_W-1:0] words,
  output logic             active,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] rr_base,
  output logic             route_ok,
  output logic [IDX_W-1:0] route_idx,
  output logic             last_beat
);
  wr_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] base_q, base_d;
  logic             fire;
  logic             upd_en;

  assign active    = (state_q == ST_BODY);
  assign cur_idx   = idx_q;
  assign rr_base   = base_q;
  assign route_ok  = active | found;
  assign route_idx = active ? idx_q : pick;
  assign last_beat = active ? (rem_q == CNT_W'(1)) : (words == CNT_W'(1));
  assign fire      = in_valid & route_ok & sel_ready;
  assign upd_en    = fire;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    base_d  = base_q;
    if (fire) begin
      if (!active) begin
        idx_d  = pick;
        base_d = IDX_W'((32'(pick) + 1) % N);
        if (words != CNT_W'(1)) begin
          state_d = ST_BODY;
          rem_d   = words - CNT_W'(1);
        end
      end else begin
        rem_d = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
    end
  end
endmodule

// File: rtl/pkt_steer_wr.sv
module pkt_steer_wr #(
  parameter int BUFF_COUNT = 4,
  parameter int DATA_W     = 128,
  parameter int MAX_BYTES  = 4096,
  parameter int LEN_LSB    = 8,
  parameter int LEN_W      = 16,
  parameter int IDX_W      = (BUFF_COUNT > 1) ? $clog2(BUFF_COUNT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DATA_W-1:0]            in_data,
  output logic [BUFF_COUNT-1:0]        buf_valid,
  output logic [BUFF_COUNT*DATA_W-1:0] buf_data,
  output logic [BUFF_COUNT-1:0]        buf_last,
  input  logic [BUFF_COUNT-1:0]        buf_ready,
  input  logic [BUFF_COUNT-1:0]        buf_empty,
  output logic [IDX_W-1:0]             wr_index
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int MAX_WORDS      = MAX_BYTES / BYTES_PER_WORD;
  localparam int CNT_W          = $clog2(MAX_WORDS + 1);

  logic [CNT_W-1:0] words;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic [IDX_W-1:0] rr_base;
  logic             pkt_active;
  logic             route_ok;
  logic [IDX_W-1:0] route_idx;
  logic             last_beat;
  logic             sel_ready;

  pws_len_decode #(
    .LEN_W(LEN_W), .BYTES_PER_WORD(BYTES_PER_WORD),
    .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
  ) u_len (
    .len_bytes(in_data[LEN_LSB +: LEN_W]),
    .words    (words)
  );

  pws_rr_pick #(.N(BUFF_COUNT), .IDX_W(IDX_W)) u_pick (
    .empty(buf_empty),
    .base (rr_base),
    .found(found),
    .pick (pick)
  );

  assign sel_ready = buf_ready[route_idx];

  pws_frame_ctrl #(.N(BUFF_COUNT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .sel_ready(sel_ready),
    .found    (found),
    .pick     (pick),
    .words    (words),
    .active   (pkt_active),
    .cur_idx  (wr_index),
    .rr_base  (rr_base),
    .route_ok (route_ok),
    .route_idx(route_idx),
    .last_beat(last_beat)
  );

  assign in_ready = route_ok & sel_ready;

  generate
    for (genvar i = 0; i < BUFF_COUNT; i++) begin : g_buf
      logic sel;
      assign sel          = route_ok & (route_idx == IDX_W'(i));
      assign buf_valid[i] = sel & in_valid;
      assign buf_last[i]  = sel & in_valid & last_beat;
      assign buf_data[i*DATA_W +: DATA_W] = sel ? in_data : '0;
    end
  endgenerate
endmodule

// File: rtl/pws_chk.sv
module pws_chk #(
  parameter int N         = 4,
  parameter int IDX_W     = 2,
  parameter int MAX_WORDS = 256,
  parameter int CNT_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [N-1:0]     buf_valid,
  input logic [N-1:0]     buf_last,
  input logic [N-1:0]     buf_ready,
  input logic [N-1:0]     buf_empty,
  input logic [IDX_W-1:0] wr_index,
  input logic             pkt_active
);
  logic             fire;
  logic [CNT_W-1:0] beats_q;

  assign fire = |(buf_valid & buf_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats_q <= '0;
    else if (fire) beats_q <= (|buf_last) ? '0 : beats_q + CNT_W'(1);
  end

  AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(buf_valid)); // R9
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) (buf_last & ~buf_valid) == '0); // R2
  AST_NO_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!pkt_active && buf_empty == '0) |-> (!in_ready && buf_valid == '0)); // R7
  AST_START_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (!pkt_active && |buf_valid) |-> |(buf_valid & buf_empty)); // R5
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (|buf_valid) |-> (in_ready == |(buf_valid & buf_ready))); // R8
  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n) (pkt_active && $past(pkt_active)) |-> $stable(wr_index)); // R10
  AST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n) fire |-> (beats_q < CNT_W'(MAX_WORDS))); // R3
endmodule

bind pkt_steer_wr pws_chk #(
  .N(BUFF_COUNT), .IDX_W(IDX_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .buf_valid (buf_valid),
  .buf_last  (buf_last),
  .buf_ready (buf_ready),
  .buf_empty (buf_empty),
  .wr_index  (wr_index),
  .pkt_active(pkt_active)
);

// File: tb/pkt_steer_wr_tb.sv
`timescale 1ns/1ps
module pkt_steer_wr_tb;
  localparam int N  = 4;
  localparam int DW = 128;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [DW-1:0]   in_data;
  logic [N-1:0]    buf_valid;
  logic [N*DW-1:0] buf_data;
  logic [N-1:0]    buf_last;
  logic [N-1:0]    buf_ready;
  logic [N-1:0]    buf_empty;
  logic [1:0]      wr_index;

  typedef struct {
    int          idx;
    logic [DW-1:0] data;
    logic        last;
  } exp_t;

  exp_t q[$];
  int   n_chk;
  int   n_fail;
  int   pkts_done;
  int   cyc;
  logic rdy_mode;
  logic finished;

  pkt_steer_wr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .buf_valid(buf_valid), .buf_data(buf_data),
    .buf_last(buf_last), .buf_ready(buf_ready), .buf_empty(buf_empty),
    .wr_index(wr_index)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_words(input int len);
    int w;
    w = (len + 15) / 16;
    if (w < 1) w = 1;
    if (w > 256) w = 256;
    return w;
  endfunction

  // Header: length at [23:8]; other header bits carry noise that must not matter.
  function automatic logic [DW-1:0] mk_hdr(input int len, input int tag);
    logic [DW-1:0] d;
    d = {32'h7157_0000 + 32'(tag), 32'h0000_1000, 40'hA5_5A00_F0_0F, 16'h0, 8'hC3};
    d[23:8] = len[15:0];
    return d;
  endfunction

  // Payload words hold a length-like value of 16 at [23:8] (R4).
  function automatic logic [DW-1:0] mk_pay(input int tag, input int w);
    return {32'(tag), 32'(w), 40'h0B0B_0B0B_0B, 16'h0010, 8'h77};
  endfunction

  task automatic send_pkt(input int len, input int exp_buf, input int tag);
    int nw;
    nw = exp_words(len);
    for (int w = 0; w < nw; w++) begin
      exp_t e;
      e.idx  = exp_buf;
      e.data = (w == 0) ? mk_hdr(len, tag) : mk_pay(tag, w);
      e.last = (w == nw - 1);
      q.push_back(e);
    end
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (w == 0) ? mk_hdr(len, tag) : mk_pay(tag, w);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      if (w == 0) begin
        #3;
        chk(wr_index == 2'(exp_buf), "R10", "wr_index after header", wr_index, exp_buf);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    pkts_done++;
  endtask

  // Ready pattern generator (R8).
  initial begin
    cyc = 0;
    buf_ready = '1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rdy_mode) buf_ready = ((cyc % 3) == 0) ? '0 : ((cyc % 5) == 0 ? 4'b1010 : '1);
      else buf_ready = '1;
    end
  end

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && (|buf_valid)) begin
        bit zero_ok;
        zero_ok = 1'b1;
        for (int i = 0; i < N; i++) begin
          if (!buf_valid[i] && (buf_data[i*DW +: DW] != '0 || buf_last[i])) zero_ok = 1'b0;
        end
        chk(zero_ok && $onehot0(buf_valid), "R9", "unselected buffers quiet", buf_valid, 0);
        chk(in_ready == |(buf_valid & buf_ready), "R8", "in_ready follows buffer ready",
            in_ready, |(buf_valid & buf_ready));
        for (int i = 0; i < N; i++) begin
          if (buf_valid[i] && buf_ready[i]) begin
            if (q.size() == 0) begin
              chk(1'b0, "R4", "beat with nothing expected", i, -1);
            end else begin
              exp_t e;
              e = q.pop_front();
              chk(i == e.idx, "R6", "destination buffer", i, e.idx);
              chk(buf_data[i*DW +: DW] == e.data, "R2", "word data",
                  longint'(buf_data[i*DW +: 64]), longint'(e.data[63:0]));
              chk(buf_last[i] == e.last, "R2", "last flag", buf_last[i], e.last);
            end
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    finished = 1'b0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; pkts_done = 0;
    rdy_mode = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    buf_empty = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(wr_index == 2'd0, "R1", "wr_index after reset", wr_index, 0);
    chk(buf_valid == '0, "R1", "no valid after reset", buf_valid, 0);

    // R1 R2: first packet to buffer 0, four words.
    send_pkt(64, 0, 1);
    // R3: back-to-back one-word packets, allocation and last in one cycle.
    send_pkt(16, 1, 2);
    send_pkt(0, 2, 3);
    // R2: length 17 rounds up to two words.
    send_pkt(17, 3, 4);

    // R3 R5 R8: clamped long packet, ready withdrawn, empty flag clears mid-packet.
    rdy_mode = 1'b1;
    fork
      begin
        repeat (20) @(negedge clk);
        buf_empty = 4'b1110;
      end
    join_none
    send_pkt(5000, 0, 5);
    rdy_mode = 1'b0;

    // R6: buffer 1 busy, search from 1 skips to 2.
    buf_empty = 4'b1101;
    send_pkt(32, 2, 6);

    // R7: no empty buffer, input held; then only buffer 0 frees (wrap).
    buf_empty = '0;
    fork
      send_pkt(48, 0, 7);
    join_none
    repeat (4) begin
      @(negedge clk);
      #2;
      chk(!in_ready && buf_valid == '0, "R7", "held while no buffer empty",
          {in_ready, buf_valid}, 0);
    end
    @(negedge clk);
    buf_empty = 4'b0001;
    wait (pkts_done == 7);
    buf_empty = '1;

    // R3: exact maximum and just above it.
    send_pkt(4096, 1, 8);
    send_pkt(4097, 2, 9);
    // R2: three words with noisy header bits.
    send_pkt(33, 3, 10);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2", "all expected words seen", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule